// File: doc/BRIEF.md
# Interval Timers with Grouped Interrupt Controller

This block is a byte-wide peripheral that holds four down-counting interval timers and three interrupt groups. A processor reaches it through an 8-bit address with separate write and read strobes. Each timer has a writable 16-bit reload value, a "start" command that loads the reload value into the counter, and a "capture" command that freezes the running count into a readable holding register. The two bytes of a count can then be read one at a time and still belong to the same sample. All counters step on a single-cycle tick enable supplied from outside, one pulse per counting period.

The interrupt side has three groups: a latched group, a level group and a fast group. Each group has a status view, an 8-bit enable mask and a request view (status AND mask). The latched group catches rising edges on five external lines and the wrap events of timers 0 and 1. It is cleared by writing ones. The level group and the fast group show their external lines as they are. The top bit of the latched group and of the fast group always reads as set, so that software can raise an interrupt by unmasking it. The processor interrupt line is the OR of the latched and level requests. The fast interrupt line is the OR of the fast requests.

Top module: `ptim_intc`

## Requirements
- R1: After reset all masks, reload values, counts, capture registers and latched status bits are zero, the read data output is 0x00, and both `irq_o` and `fiq_o` are low.
- R2: Timer n is decoded at base 0x40 + 0x10·n. A write at base+0x0 sets the low reload byte and a write at base+0x4 sets the high reload byte. A read at base+0x0 or base+0x4 returns the low or high byte of that timer's capture register. Read data is registered: it appears on the clock edge that samples the read strobe and holds until the next read.
- R3: A tick with a non-zero count decrements the count by one. A tick with a zero count reloads the count from the reload value, so a timer repeats every reload+1 ticks. Without a tick the count holds.
- R4: A write at base+0x8 loads the reload value into the count on that edge. It takes precedence over a tick in the same cycle.
- R5: A write at base+0xC copies the current count into the capture register. The capture register keeps that value while the count moves on, until the next capture.
- R6: A zero-count tick on timer 0 sets latched bit 5 and one on timer 1 sets latched bit 6. Timers 2 and 3 set no status bit.
- R7: Latched bits 4..0 are set by a rising edge on `irqa_edge_i[4:0]` and stay set after the line falls. Writing 0x14 clears exactly the bits written as 1. A line held high does not set its bit again after a clear. A set event in the same cycle as its clear wins.
- R8: Bit 7 of the latched status (0x10) and bit 7 of the fast status (0x30) always read as 1, and writing 0xFF to 0x14 does not clear latched bit 7.
- R9: The level status at 0x20 equals `irqb_lvl_i` in every cycle. Writes to 0x20 and 0x24 change neither the status nor the mask.
- R10: Bits 6..0 of the fast status at 0x30 equal `fiq_lvl_i`.
- R11: The masks are read and written at 0x18, 0x28 and 0x38. The requests at 0x14, 0x24 and 0x34 read as status AND mask.
- R12: `irq_o` is high exactly when the latched request or the level request is non-zero. `fiq_o` is high exactly when the fast request is non-zero.
- R13: A read of any address not listed in R2, R8–R11 returns 0x00. This includes base+0x8 and base+0xC of each timer and addresses 0x00–0x0F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count enable, one cycle per counting period |
| bus_addr_i | input | 8 | Byte address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| irqa_edge_i | input | 5 | Edge-detected sources for latched bits 4..0 |
| irqb_lvl_i | input | 8 | Level sources for the level group |
| fiq_lvl_i | input | 7 | Level sources for fast bits 6..0 |
| irq_o | output | 1 | Combined normal interrupt request |
| fiq_o | output | 1 | Combined fast interrupt request |

## Verification
Each timer is run with reload values 0, 1, 2, 3 and 7 through more than two full periods, with a capture at every tick. The expected count is computed as reload minus (ticks mod (reload+1)), which separates an off-by-one period from a wrong reload value. The level and fast groups are swept over every input value under several masks (all-off, all-on, alternating and top-bit only), which exposes swapped or stuck bits in the status, request and combined-output paths. The latched group is driven with single-bit edges, partial clears, a line held high across a clear and a set that coincides with its clear, so that edge capture is told apart from level capture and set priority from clear priority. An address sweep confirms that every undecoded offset reads zero.

// File: rtl/ptim_pkg.sv
package ptim_pkg;

   localparam logic [7:0] OFS_A_STAT = 8'h10;
   localparam logic [7:0] OFS_A_REQ  = 8'h14;
   localparam logic [7:0] OFS_A_MASK = 8'h18;
   localparam logic [7:0] OFS_B_STAT = 8'h20;
   localparam logic [7:0] OFS_B_REQ  = 8'h24;
   localparam logic [7:0] OFS_B_MASK = 8'h28;
   localparam logic [7:0] OFS_F_STAT = 8'h30;
   localparam logic [7:0] OFS_F_REQ  = 8'h34;
   localparam logic [7:0] OFS_F_MASK = 8'h38;

   localparam int MAX_TMR   = 4;
   localparam int GRP_W     = 8;
   localparam int EDGE_SRCS = 5;

   // sub-register select inside one timer window, taken from address bits 3:2
   typedef enum logic [1:0] {
      TSUB_LO   = 2'd0,
      TSUB_HI   = 2'd1,
      TSUB_GO   = 2'd2,
      TSUB_SNAP = 2'd3
   } tsub_e;

   typedef struct packed {
      logic wr_lo;
      logic wr_hi;
      logic go;
      logic snap;
   } tmr_cmd_t;

endpackage

// File: rtl/ptim_counter.sv
module ptim_counter
   import ptim_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     tick_i,
   input  tmr_cmd_t cmd_i,
   input  logic [7:0] wdata_i,
   output logic [7:0] snap_lo_o,
   output logic [7:0] snap_hi_o,
   output logic     wrap_o
);

   localparam int HI_W = CNT_W - 8;
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   generate
      if (CNT_W < 9 || CNT_W > 16) begin : g_bad_width
         $error("ptim_counter: CNT_W must lie in 9..16");
      end
   endgenerate

   logic [CNT_W-1:0] reload_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] snap_q;
   logic             at_zero;

   assign at_zero = (cnt_q == '0);
   assign wrap_o  = tick_i & at_zero;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reload_q <= '0;
      end else begin
         if (cmd_i.wr_lo) reload_q[7:0]       <= wdata_i;
         if (cmd_i.wr_hi) reload_q[CNT_W-1:8] <= wdata_i[HI_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cmd_i.go) begin
         cnt_q <= reload_q;
      end else if (tick_i) begin
         cnt_q <= at_zero ? reload_q : (cnt_q - ONE);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snap_q <= '0;
      end else if (cmd_i.snap) begin
         snap_q <= cnt_q;
      end
   end

   assign snap_lo_o = snap_q[7:0];

   generate
      if (HI_W == 8) begin : g_hi_full
         assign snap_hi_o = snap_q[CNT_W-1:8];
      end else begin : g_hi_pad
         assign snap_hi_o = {{(8-HI_W){1'b0}}, snap_q[CNT_W-1:8]};
      end
   endgenerate

   p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !cmd_i.go && !at_zero) |=> (cnt_q == $past(cnt_q) - ONE))
      else $error("count did not step down");

   p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !cmd_i.go && at_zero) |=> (cnt_q == $past(reload_q)))
      else $error("count did not reload at zero");

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !cmd_i.go) |=> $stable(cnt_q))
      else $error("count moved without tick");

   p_go_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_i.go |=> (cnt_q == $past(reload_q)))
      else $error("start command did not load count");

   p_snap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_i.snap |=> (snap_q == $past(cnt_q)))
      else $error("capture missed count");

   p_snap_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_i.snap |=> $stable(snap_q))
      else $error("capture register drifted");

endmodule

// File: rtl/ptim_irq_grp.sv
module ptim_irq_grp #(
   parameter int           W       = 8,
   parameter bit           LATCHED = 1'b0,
   parameter logic [W-1:0] FORCE   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] src_i,
   input  logic [W-1:0] clr_i,
   input  logic         mask_we_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] status_o,
   output logic [W-1:0] request_o,
   output logic [W-1:0] mask_o,
   output logic         any_o
);

   generate
      if (W < 1 || W > 8) begin : g_bad_w
         $error("ptim_irq_grp: W must lie in 1..8");
      end
   endgenerate

   logic [W-1:0] mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n)         mask_q <= '0;
      else if (mask_we_i) mask_q <= wdata_i;
   end

   generate
      if (LATCHED) begin : g_latched
         logic [W-1:0] stat_q;

         always_ff @(posedge clk) begin
            if (!rst_n) stat_q <= '0;
            else        stat_q <= (stat_q & ~clr_i) | src_i;
         end

         assign status_o = stat_q | FORCE;

         p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (|src_i) |=> ((stat_q & $past(src_i)) == $past(src_i)))
            else $error("latched bit not set by event");

         p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (|clr_i) |=> ((stat_q & $past(clr_i) & ~$past(src_i)) == '0))
            else $error("latched bit survived clear");

         p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i == '0) |=> (($past(stat_q) & ~stat_q) == '0))
            else $error("latched bit dropped without clear");
      end else begin : g_level
         logic unused_clr;
         assign unused_clr = |clr_i;
         assign status_o   = src_i | FORCE;
      end
   endgenerate

   assign mask_o    = mask_q;
   assign request_o = status_o & mask_q;
   assign any_o     = |request_o;

   p_mask_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we_i |=> (mask_q == $past(wdata_i)))
      else $error("mask write lost");

   p_mask_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_we_i |=> $stable(mask_q))
      else $error("mask changed without write");

endmodule

// File: rtl/ptim_intc.sv
module ptim_intc
   import ptim_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int N_TMR = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic [7:0] bus_addr_i,
   input  logic       bus_wr_i,
   input  logic       bus_rd_i,
   input  logic [7:0] bus_wdata_i,
   output logic [7:0] bus_rdata_o,
   input  logic [4:0] irqa_edge_i,
   input  logic [7:0] irqb_lvl_i,
   input  logic [6:0] fiq_lvl_i,
   output logic       irq_o,
   output logic       fiq_o
);

   generate
      if (N_TMR < 2 || N_TMR > MAX_TMR) begin : g_bad_ntmr
         $error("ptim_intc: N_TMR must lie in 2..4");
      end
   endgenerate

   // ---------------- address decode ----------------
   logic       tmr_win;
   logic       tmr_ok;
   logic [1:0] tmr_idx;
   tsub_e      tmr_sub;

   assign tmr_idx = bus_addr_i[5:4];
   assign tmr_sub = tsub_e'(bus_addr_i[3:2]);
   assign tmr_win = (bus_addr_i[7:6] == 2'b01) && (bus_addr_i[1:0] == 2'b00);
   assign tmr_ok  = tmr_win && (int'(tmr_idx) < N_TMR);

   // ---------------- timers ----------------
   logic [7:0]         t_lo [MAX_TMR];
   logic [7:0]         t_hi [MAX_TMR];
   logic [MAX_TMR-1:0] wrap;

   generate
      for (genvar g = 0; g < MAX_TMR; g++) begin : g_tmr
         if (g < N_TMR) begin : g_live
            tmr_cmd_t cmd;
            logic     sel;
            assign sel       = bus_wr_i && tmr_win && (tmr_idx == 2'(g));
            assign cmd.wr_lo = sel && (tmr_sub == TSUB_LO);
            assign cmd.wr_hi = sel && (tmr_sub == TSUB_HI);
            assign cmd.go    = sel && (tmr_sub == TSUB_GO);
            assign cmd.snap  = sel && (tmr_sub == TSUB_SNAP);

            ptim_counter #(.CNT_W(CNT_W)) u_cnt (
               .clk       (clk),
               .rst_n     (rst_n),
               .tick_i    (tick_i),
               .cmd_i     (cmd),
               .wdata_i   (bus_wdata_i),
               .snap_lo_o (t_lo[g]),
               .snap_hi_o (t_hi[g]),
               .wrap_o    (wrap[g])
            );
         end else begin : g_absent
            assign t_lo[g] = 8'h00;
            assign t_hi[g] = 8'h00;
            assign wrap[g] = 1'b0;
         end
      end
   endgenerate

   logic unused_wrap;
   assign unused_wrap = |wrap[MAX_TMR-1:2];

   // ---------------- latched group edge capture ----------------
   logic [EDGE_SRCS-1:0] edge_q;
   logic [EDGE_SRCS-1:0] rise;

   always_ff @(posedge clk) begin
      if (!rst_n) edge_q <= '0;
      else        edge_q <= irqa_edge_i;
   end

   assign rise = irqa_edge_i & ~edge_q;

   // ---------------- interrupt groups ----------------
   logic [GRP_W-1:0] src_a, src_f, clr_a;
   logic [GRP_W-1:0] stat_a, req_a, mask_a;
   logic [GRP_W-1:0] stat_b, req_b, mask_b;
   logic [GRP_W-1:0] stat_f, req_f, mask_f;
   logic             any_a, any_b, any_f;

   assign src_a = {1'b0, wrap[1], wrap[0], rise};
   assign src_f = {1'b0, fiq_lvl_i};
   assign clr_a = (bus_wr_i && (bus_addr_i == OFS_A_REQ)) ? bus_wdata_i : '0;

   ptim_irq_grp #(.W(GRP_W), .LATCHED(1'b1), .FORCE(8'h80)) u_grp_a (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_i     (src_a),
      .clr_i     (clr_a),
      .mask_we_i (bus_wr_i && (bus_addr_i == OFS_A_MASK)),
      .wdata_i   (bus_wdata_i),
      .status_o  (stat_a),
      .request_o (req_a),
      .mask_o    (mask_a),
      .any_o     (any_a)
   );

   ptim_irq_grp #(.W(GRP_W), .LATCHED(1'b0), .FORCE(8'h00)) u_grp_b (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_i     (irqb_lvl_i),
      .clr_i     ('0),
      .mask_we_i (bus_wr_i && (bus_addr_i == OFS_B_MASK)),
      .wdata_i   (bus_wdata_i),
      .status_o  (stat_b),
      .request_o (req_b),
      .mask_o    (mask_b),
      .any_o     (any_b)
   );

   ptim_irq_grp #(.W(GRP_W), .LATCHED(1'b0), .FORCE(8'h80)) u_grp_f (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_i     (src_f),
      .clr_i     ('0),
      .mask_we_i (bus_wr_i && (bus_addr_i == OFS_F_MASK)),
      .wdata_i   (bus_wdata_i),
      .status_o  (stat_f),
      .request_o (req_f),
      .mask_o    (mask_f),
      .any_o     (any_f)
   );

   assign irq_o = any_a | any_b;
   assign fiq_o = any_f;

   // ---------------- read path ----------------
   logic [7:0] rd_mux;
   logic       rd_map;
   logic [7:0] rdata_q;

   always_comb begin
      rd_mux = 8'h00;
      rd_map = 1'b1;
      case (bus_addr_i)
         OFS_A_STAT: rd_mux = stat_a;
         OFS_A_REQ:  rd_mux = req_a;
         OFS_A_MASK: rd_mux = mask_a;
         OFS_B_STAT: rd_mux = stat_b;
         OFS_B_REQ:  rd_mux = req_b;
         OFS_B_MASK: rd_mux = mask_b;
         OFS_F_STAT: rd_mux = stat_f;
         OFS_F_REQ:  rd_mux = req_f;
         OFS_F_MASK: rd_mux = mask_f;
         default: begin
            if (tmr_ok && tmr_sub == TSUB_LO)      rd_mux = t_lo[tmr_idx];
            else if (tmr_ok && tmr_sub == TSUB_HI) rd_mux = t_hi[tmr_idx];
            else                                   rd_map = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        rdata_q <= 8'h00;
      else if (bus_rd_i) rdata_q <= rd_mux;
   end

   assign bus_rdata_o = rdata_q;

   p_unmapped_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_i && !rd_map) |=> (bus_rdata_o == 8'h00))
      else $error("undecoded read returned data");

   p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_i |=> $stable(bus_rdata_o))
      else $error("read data moved without read");

   p_irq_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ((mask_a == '0) && (mask_b == '0)) |-> !irq_o)
      else $error("irq raised with all masks clear");

   p_fiq_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_f == '0) |-> !fiq_o)
      else $error("fiq raised with mask clear");

endmodule

// File: tb/ptim_intc_bench.sv
module ptim_intc_bench;

   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 150000;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       tick;
   logic [7:0] addr;
   logic       wr;
   logic       rd;
   logic [7:0] wdata;
   logic [7:0] rdata;
   logic [4:0] ea;
   logic [7:0] lb;
   logic [6:0] lf;
   logic       irq;
   logic       fiq;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ptim_intc u_ptim_intc (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (tick),
      .bus_addr_i  (addr),
      .bus_wr_i    (wr),
      .bus_rd_i    (rd),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .irqa_edge_i (ea),
      .irqb_lvl_i  (lb),
      .fiq_lvl_i   (lf),
      .irq_o       (irq),
      .fiq_o       (fiq)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
      d = rdata;
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
      logic [7:0] d;
      rd_reg(a, d);
      chk(tag, d, exp);
   endtask

   task automatic do_tick(input int cnt);
      for (int i = 0; i < cnt; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   function automatic logic [7:0] tbase(input int n);
      return 8'(8'h40 + 16 * n);
   endfunction

   function automatic bit is_mapped(input logic [7:0] a);
      if (a == 8'h10 || a == 8'h14 || a == 8'h18 || a == 8'h20 || a == 8'h24 ||
          a == 8'h28 || a == 8'h30 || a == 8'h34 || a == 8'h38) return 1'b1;
      if (a >= 8'h40 && a < 8'h80 && a[1:0] == 2'b00 && a[3] == 1'b0) return 1'b1;
      return 1'b0;
   endfunction

   task automatic load_go(input int n, input int val);
      wr_reg(tbase(n),        8'(val));
      wr_reg(tbase(n) + 8'h4, 8'(val >> 8));
      wr_reg(tbase(n) + 8'h8, 8'h00);
   endtask

   task automatic snap_chk(input string tag, input int n, input int exp);
      wr_reg(tbase(n) + 8'hC, 8'h00);
      rd_chk(tag, tbase(n),        8'(exp));
      rd_chk(tag, tbase(n) + 8'h4, 8'(exp >> 8));
   endtask

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [7:0] d;
      logic [7:0] masks [4];
      rst_n = 1'b0; tick = 1'b0; addr = '0; wr = 1'b0; rd = 1'b0; wdata = '0;
      ea = '0; lb = '0; lf = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 rdata", rdata, 8'h00);
      chk("R1 irq", {7'b0, irq}, 8'h00);
      chk("R1 fiq", {7'b0, fiq}, 8'h00);
      rd_chk("R1 mask A", 8'h18, 8'h00);
      rd_chk("R1 mask B", 8'h28, 8'h00);
      rd_chk("R1 mask F", 8'h38, 8'h00);
      rd_chk("R1 stat A", 8'h10, 8'h80);
      rd_chk("R1 req A", 8'h14, 8'h00);
      for (int n = 0; n < 4; n++) begin
         rd_chk("R1 tmr lo", tbase(n), 8'h00);
         rd_chk("R1 tmr hi", tbase(n) + 8'h4, 8'h00);
      end

      // R13 address sweep
      for (int a = 0; a < 256; a++) begin
         if (!is_mapped(8'(a))) rd_chk("R13 unmapped", 8'(a), 8'h00);
      end

      // R2 / R4 / R5 byte access per timer
      for (int n = 0; n < 4; n++) begin
         wr_reg(tbase(n), 8'(8'h12 + n));
         wr_reg(tbase(n) + 8'h4, 8'hAB);
         wr_reg(tbase(n) + 8'h8, 8'h00);
         snap_chk("R2 bytes", n, 16'hAB12 + n);
         rd_chk("R2 hold", tbase(n), 8'(8'h12 + n));
      end

      // R3 counting sweep: count = L - (k mod (L+1))
      for (int n = 0; n < 4; n++) begin
         int lv [5] = '{0, 1, 2, 3, 7};
         foreach (lv[j]) begin
            load_go(n, lv[j]);
            for (int k = 0; k <= 2 * lv[j] + 3; k++) begin
               snap_chk("R3 count", n, lv[j] - (k % (lv[j] + 1)));
               do_tick(1);
            end
         end
         // R5 capture keeps value while counting
         load_go(n, 5);
         snap_chk("R5 capture", n, 5);
         do_tick(3);
         rd_chk("R5 held", tbase(n), 8'h05);
         snap_chk("R5 recapture", n, 2);
         // R4 start beats tick in same cycle
         @(negedge clk);
         addr = tbase(n) + 8'h8; wr = 1'b1; tick = 1'b1;
         @(negedge clk);
         wr = 1'b0; tick = 1'b0;
         snap_chk("R4 start over tick", n, 5);
      end

      // R6 timer to status bit mapping
      for (int n = 0; n < 4; n++) load_go(n, 16'h0100);
      for (int n = 0; n < 4; n++) begin
         load_go(n, 2);
         wr_reg(8'h14, 8'hFF);
         do_tick(2);
         rd_chk("R6 before wrap", 8'h10, 8'h80);
         do_tick(1);
         rd_chk("R6 after wrap", 8'h10,
                8'h80 | (n == 0 ? 8'h20 : (n == 1 ? 8'h40 : 8'h00)));
         load_go(n, 16'h0100);
      end
      chk("R12 irq masked", {7'b0, irq}, 8'h00);

      // R7 edge capture and clear
      wr_reg(8'h14, 8'hFF);
      for (int k = 0; k < 5; k++) begin
         @(negedge clk); ea = 5'(1 << k);
         @(negedge clk); ea = '0;
         rd_chk("R7 edge set", 8'h10, 8'(8'h80 | (1 << k)));
         wr_reg(8'h14, 8'(~(1 << k) & 8'h1F));
         rd_chk("R7 other clear", 8'h10, 8'(8'h80 | (1 << k)));
         wr_reg(8'h14, 8'(1 << k));
         rd_chk("R7 cleared", 8'h10, 8'h80);
         @(negedge clk); ea = 5'(1 << k);
         wr_reg(8'h14, 8'(1 << k));
         rd_chk("R7 held high", 8'h10, 8'h80);
         @(negedge clk); ea = '0;
         @(negedge clk);
         ea = 5'(1 << k); addr = 8'h14; wdata = 8'(1 << k); wr = 1'b1;
         @(negedge clk);
         wr = 1'b0; ea = '0;
         rd_chk("R7 set wins", 8'h10, 8'(8'h80 | (1 << k)));
         wr_reg(8'h14, 8'hFF);
      end

      // R8 force bits
      wr_reg(8'h14, 8'hFF);
      rd_chk("R8 force A", 8'h10, 8'h80);
      rd_chk("R8 force F", 8'h30, 8'h80);

      // R11 / R12 latched group requests
      wr_reg(8'h18, 8'h80);
      chk("R12 force irq", {7'b0, irq}, 8'h01);
      rd_chk("R11 req A force", 8'h14, 8'h80);
      wr_reg(8'h18, 8'h01);
      chk("R12 irq off", {7'b0, irq}, 8'h00);
      @(negedge clk); ea = 5'b00001;
      @(negedge clk); ea = '0;
      rd_chk("R11 req A", 8'h14, 8'h01);
      chk("R12 irq A", {7'b0, irq}, 8'h01);
      wr_reg(8'h14, 8'h01);
      chk("R12 irq cleared", {7'b0, irq}, 8'h00);
      rd_chk("R11 mask A", 8'h18, 8'h01);
      wr_reg(8'h18, 8'h00);

      // R9 / R11 / R12 level group sweep
      masks = '{8'h00, 8'hFF, 8'h5A, 8'h80};
      foreach (masks[m]) begin
         wr_reg(8'h28, masks[m]);
         for (int v = 0; v < 256; v++) begin
            @(negedge clk); lb = 8'(v);
            rd_chk("R9 stat B", 8'h20, 8'(v));
            rd_chk("R11 req B", 8'h24, 8'(v) & masks[m]);
            chk("R12 irq B", {7'b0, irq}, {7'b0, |(8'(v) & masks[m])});
         end
      end
      @(negedge clk); lb = 8'h3C;
      wr_reg(8'h24, 8'hFF);
      wr_reg(8'h20, 8'hFF);
      rd_chk("R9 no clear", 8'h20, 8'h3C);
      rd_chk("R9 mask kept", 8'h28, 8'h80);
      wr_reg(8'h28, 8'h00);
      @(negedge clk); lb = '0;

      // R10 / R11 / R12 fast group sweep
      masks = '{8'h00, 8'hFF, 8'h0F, 8'h80};
      foreach (masks[m]) begin
         wr_reg(8'h38, masks[m]);
         for (int v = 0; v < 128; v++) begin
            @(negedge clk); lf = 7'(v);
            rd_chk("R10 stat F", 8'h30, 8'(8'h80 | v));
            rd_chk("R11 req F", 8'h34, 8'(8'h80 | v) & masks[m]);
            chk("R12 fiq", {7'b0, fiq}, {7'b0, |(8'(8'h80 | v) & masks[m])});
         end
      end

      finish_run();
   end

endmodule